// File: doc/BRIEF.md
# Banked Physical Register File with Result-Time Register Binding

This block is the physical register storage of an out-of-order core. It is split into several equal banks. Each bank has two read ports and one write port, and each bank is tied to exactly one result bus. A physical register is not reserved when an instruction is renamed. It is taken from the bank's own pool of unused registers when the result bus wins write arbitration, two cycles before the result data arrives. No two results can ever contend for the same write port, so each bank stays as small and as fast as a scalar register file.

Result-bus arbitration presents one allocation request per bus on a valid/ready pair. `alloc_ready` is a combinational answer in the same cycle. While `alloc_ready` is low the request counts as stalled: the producing functional unit holds the request and its tag, and keeps `alloc_valid` high in the following cycles until `alloc_ready` rises. The block never drops or queues a stalled request, and it accepts at most one request per bus per cycle. The oldest in-flight instruction may name the register it is about to retire from its recovery entry. It then writes there and is never stalled. Commit returns old registers through free ports. Operand reads are arbitrated per bank, in the same cycle they are requested. After each accepted allocation, the block broadcasts the (tag, register) pair so that the instruction window and the rename state can bind to it.

Top module: `wrbank_regfile`

## Requirements
- R1: After reset, registers with index below LOGICAL_PER_BANK in every bank read as zero and are held out of the pool, and every other register is in its bank's pool. The first allocation on bus b therefore returns index LOGICAL_PER_BANK.
- R2: A physical register number is {bank, index}, with the bank in the upper BANK_W bits. An accepted normal allocation on bus b takes the lowest-index free register of bank b and reports it on `alloc_preg[b]` in the same cycle.
- R3: When bank b has no free register and `alloc_oldest[b]` is low, `alloc_ready[b]` is low (a stall) and nothing is taken. The same request is accepted in a later cycle once a register has been returned.
- R4: A register named on a valid free port returns to the pool of the bank in its upper bits and can be allocated from the next cycle on. Without a free, an empty pool stays empty.
- R5: The data on `res_data[b]` two cycles after an accepted allocation on bus b is written into the allocated register, and it is readable from the following cycle.
- R6: Per bank and per cycle, at most two read requests are granted, taken in ascending requester index. Every further request to that bank gets `rd_fail`, in the same cycle. A requester with `rd_valid` low gets neither `rd_grant` nor `rd_fail`.
- R7: A granted read returns, in the same cycle, the current content of the addressed register.
- R8: With `alloc_oldest[b]` high, the request is always accepted, `alloc_preg[b]` is {b, `alloc_old_idx[b]`}, and bank b's pool is left untouched.
- R9: One cycle after an accepted allocation on bus b, `bc_valid[b]` is high and `bc_tag[b]`/`bc_preg[b]` carry that request's tag and register. In any other cycle `bc_valid[b]` is low.
- R10: The banks work independently: requests on all buses in the same cycle are all accepted when every bank has a free register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | NUM_BANKS | Allocation request per result bus |
| alloc_tag | input | NUM_BANKS x TAG_W | Instruction tag of each request |
| alloc_oldest | input | NUM_BANKS | Request belongs to the oldest in-flight instruction |
| alloc_old_idx | input | NUM_BANKS x IDX_W | Register index in the bus's own bank reused by the oldest instruction |
| alloc_ready | output | NUM_BANKS | Request accepted this cycle; low with valid means stall |
| alloc_preg | output | NUM_BANKS x PREG_W | Register given to the request |
| res_data | input | NUM_BANKS x DATA_W | Result data, two cycles after acceptance |
| free_valid | input | NUM_FREES | Commit-time release strobe |
| free_preg | input | NUM_FREES x PREG_W | Register released |
| rd_valid | input | NUM_READERS | Operand read request |
| rd_preg | input | NUM_READERS x PREG_W | Register to read |
| rd_grant | output | NUM_READERS | Read served this cycle |
| rd_fail | output | NUM_READERS | Read refused for lack of a bank port |
| rd_data | output | NUM_READERS x DATA_W | Read data (zero when not granted) |
| bc_valid | output | NUM_BANKS | Binding broadcast valid |
| bc_tag | output | NUM_BANKS x TAG_W | Tag of the bound result |
| bc_preg | output | NUM_BANKS x PREG_W | Register bound to that tag |

## Verification
The hardest state to reach is a bank whose pool is empty while its bus keeps requesting. Only then do the stall, the oldest-instruction path that bypasses the pool, and the retry after a release become visible. The bench drives one bus on every cycle until all six free registers of that bank are gone. In the empty state it first applies a plain request and then an oldest request, and it then releases one register and watches the retry pick it up. Long random traffic then mixes releases, oldest requests and crowded read ports against a behavioural model that predicts every output on every cycle.

// File: rtl/wrbank_pkg.sv
package wrbank_pkg;
  // Which of a bank's two read ports serves a requester.
  typedef enum logic [1:0] {
    SLOT_NONE = 2'd0,
    SLOT_A    = 2'd1,
    SLOT_B    = 2'd2
  } rd_slot_e;

  localparam int PORTS_PER_BANK = 2;
endpackage

// File: rtl/wrbank_freelist.sv
module wrbank_freelist #(
  parameter int REGS = 8,
  parameter int RESV = 2,
  localparam int IW  = $clog2(REGS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take,
  input  logic [REGS-1:0] rel_mask,
  output logic            has_free,
  output logic [IW-1:0]   pick_idx
);
  logic [REGS-1:0] pool_q;
  logic [REGS-1:0] take_mask;

  // lowest set bit wins
  always_comb begin
    pick_idx = '0;
    for (int r = REGS - 1; r >= 0; r--) begin
      if (pool_q[r]) pick_idx = IW'(r);
    end
  end

  assign has_free  = |pool_q;
  assign take_mask = take ? (REGS'(1) << pick_idx) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < REGS; r++) pool_q[r] <= (r >= RESV);
    end else begin
      pool_q <= (pool_q & ~take_mask) | rel_mask;
    end
  end

  // R2: a taken register leaves the pool unless released in the same cycle
  p_pick_leaves_pool_r2: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (!pool_q[$past(pick_idx)] || $past(rel_mask[pick_idx])));
endmodule

// File: rtl/wrbank_store.sv
module wrbank_store #(
  parameter int REGS = 8,
  parameter int DW   = 16,
  localparam int IW  = $clog2(REGS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                acc,
  input  logic [IW-1:0]       acc_idx,
  input  logic [DW-1:0]       wdata,
  input  logic [1:0][IW-1:0]  raddr,
  output logic [1:0][DW-1:0]  rdata
);
  logic [REGS-1:0][DW-1:0] cell_q;
  logic                    s1_v, s2_v;
  logic [IW-1:0]           s1_i, s2_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cell_q <= '0;
      s1_v   <= 1'b0;
      s2_v   <= 1'b0;
      s1_i   <= '0;
      s2_i   <= '0;
    end else begin
      s1_v <= acc;
      s1_i <= acc_idx;
      s2_v <= s1_v;
      s2_i <= s1_i;
      if (s2_v) cell_q[s2_i] <= wdata;
    end
  end

  for (genvar k = 0; k < 2; k++) begin : g_rport
    assign rdata[k] = cell_q[raddr[k]];
  end

  // R5: the write lands two cycles after acceptance, at the accepted index
  p_write_two_late_r5: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> ##1 (s2_v && s2_i == $past(acc_idx, 2)));
endmodule

// File: rtl/wrbank_rdarb.sv
module wrbank_rdarb
  import wrbank_pkg::*;
#(
  parameter int NR = 6,
  parameter int NB = 4,
  localparam int BW = $clog2(NB)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NR-1:0]         rd_valid,
  input  logic [NR-1:0][BW-1:0] rd_bank,
  output logic [NR-1:0]         grant,
  output logic [NR-1:0]         fail,
  output rd_slot_e              slot [NR]
);
  always_comb begin
    int used [NB];
    for (int b = 0; b < NB; b++) used[b] = 0;
    grant = '0;
    fail  = '0;
    for (int i = 0; i < NR; i++) begin
      slot[i] = SLOT_NONE;
      if (rd_valid[i]) begin
        if (used[rd_bank[i]] < PORTS_PER_BANK) begin
          grant[i] = 1'b1;
          slot[i]  = (used[rd_bank[i]] == 0) ? SLOT_A : SLOT_B;
        end else begin
          fail[i] = 1'b1;
        end
        used[rd_bank[i]] = used[rd_bank[i]] + 1;
      end
    end
  end

  for (genvar b = 0; b < NB; b++) begin : g_bchk
    logic [NR-1:0] hit;
    for (genvar i = 0; i < NR; i++) begin : g_hit
      assign hit[i] = grant[i] && (rd_bank[i] == BW'(b));
    end
    // R6: never more than the two physical ports of a bank
    p_two_ports_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(hit) <= 2);
  end

  for (genvar i = 0; i < NR; i++) begin : g_rchk
    // R6: each live request resolves to exactly one of grant or fail
    p_resolved_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid[i] |-> (grant[i] ^ fail[i]));
    p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_valid[i] |-> !(grant[i] || fail[i]));
  end
endmodule

// File: rtl/wrbank_regfile.sv
module wrbank_regfile
  import wrbank_pkg::*;
#(
  parameter int NUM_BANKS        = 4,
  parameter int BANK_REGS        = 8,
  parameter int LOGICAL_PER_BANK = 2,
  parameter int DATA_W           = 16,
  parameter int TAG_W            = 6,
  parameter int NUM_READERS      = 6,
  parameter int NUM_FREES        = 2,
  localparam int BANK_W = $clog2(NUM_BANKS),
  localparam int IDX_W  = $clog2(BANK_REGS),
  localparam int PREG_W = BANK_W + IDX_W
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic [NUM_BANKS-1:0]                   alloc_valid,
  input  logic [NUM_BANKS-1:0][TAG_W-1:0]        alloc_tag,
  input  logic [NUM_BANKS-1:0]                   alloc_oldest,
  input  logic [NUM_BANKS-1:0][IDX_W-1:0]        alloc_old_idx,
  output logic [NUM_BANKS-1:0]                   alloc_ready,
  output logic [NUM_BANKS-1:0][PREG_W-1:0]       alloc_preg,
  input  logic [NUM_BANKS-1:0][DATA_W-1:0]       res_data,
  input  logic [NUM_FREES-1:0]                   free_valid,
  input  logic [NUM_FREES-1:0][PREG_W-1:0]       free_preg,
  input  logic [NUM_READERS-1:0]                 rd_valid,
  input  logic [NUM_READERS-1:0][PREG_W-1:0]     rd_preg,
  output logic [NUM_READERS-1:0]                 rd_grant,
  output logic [NUM_READERS-1:0]                 rd_fail,
  output logic [NUM_READERS-1:0][DATA_W-1:0]     rd_data,
  output logic [NUM_BANKS-1:0]                   bc_valid,
  output logic [NUM_BANKS-1:0][TAG_W-1:0]        bc_tag,
  output logic [NUM_BANKS-1:0][PREG_W-1:0]       bc_preg
);
  logic [NUM_BANKS-1:0]                    has_free, take, acc;
  logic [NUM_BANKS-1:0][IDX_W-1:0]         pick, use_idx;
  logic [NUM_BANKS-1:0][BANK_REGS-1:0]     rel;
  logic [NUM_BANKS-1:0][1:0][IDX_W-1:0]    port_addr;
  logic [NUM_BANKS-1:0][1:0][DATA_W-1:0]   port_data;
  logic [NUM_READERS-1:0][BANK_W-1:0]      rd_bank;
  rd_slot_e                                rd_slot [NUM_READERS];

  // route commit-time releases to the owning bank
  always_comb begin
    rel = '0;
    for (int f = 0; f < NUM_FREES; f++) begin
      if (free_valid[f])
        rel[free_preg[f][PREG_W-1:IDX_W]][free_preg[f][IDX_W-1:0]] = 1'b1;
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign alloc_ready[b] = alloc_oldest[b] | has_free[b];
    assign take[b]        = alloc_valid[b] & ~alloc_oldest[b] & has_free[b];
    assign acc[b]         = alloc_valid[b] & alloc_ready[b];
    assign use_idx[b]     = alloc_oldest[b] ? alloc_old_idx[b] : pick[b];
    assign alloc_preg[b]  = {BANK_W'(b), use_idx[b]};

    wrbank_freelist #(.REGS(BANK_REGS), .RESV(LOGICAL_PER_BANK)) u_pool (
      .clk      (clk),
      .rst_n    (rst_n),
      .take     (take[b]),
      .rel_mask (rel[b]),
      .has_free (has_free[b]),
      .pick_idx (pick[b])
    );

    wrbank_store #(.REGS(BANK_REGS), .DW(DATA_W)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .acc     (acc[b]),
      .acc_idx (use_idx[b]),
      .wdata   (res_data[b]),
      .raddr   (port_addr[b]),
      .rdata   (port_data[b])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bc_valid[b] <= 1'b0;
        bc_tag[b]   <= '0;
        bc_preg[b]  <= '0;
      end else begin
        bc_valid[b] <= acc[b];
        bc_tag[b]   <= alloc_tag[b];
        bc_preg[b]  <= alloc_preg[b];
      end
    end

    // R9: every accepted request is announced one cycle later with its own pair
    p_bcast_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
      acc[b] |=> (bc_valid[b] && bc_tag[b] == $past(alloc_tag[b])
                  && bc_preg[b] == $past(alloc_preg[b])));
    p_bcast_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !acc[b] |=> !bc_valid[b]);
    // R4: an empty pool refills only through a release
    p_refill_by_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!has_free[b] && rel[b] == '0) |=> !has_free[b]);
  end

  for (genvar i = 0; i < NUM_READERS; i++) begin : g_rbank
    assign rd_bank[i] = rd_preg[i][PREG_W-1:IDX_W];
  end

  wrbank_rdarb #(.NR(NUM_READERS), .NB(NUM_BANKS)) u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_valid (rd_valid),
    .rd_bank  (rd_bank),
    .grant    (rd_grant),
    .fail     (rd_fail),
    .slot     (rd_slot)
  );

  // steer granted requesters onto their bank's port addresses
  always_comb begin
    port_addr = '0;
    for (int i = 0; i < NUM_READERS; i++) begin
      if (rd_grant[i]) begin
        if (rd_slot[i] == SLOT_B) port_addr[rd_bank[i]][1] = rd_preg[i][IDX_W-1:0];
        else                      port_addr[rd_bank[i]][0] = rd_preg[i][IDX_W-1:0];
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_READERS; i++) begin
      rd_data[i] = '0;
      if (rd_grant[i])
        rd_data[i] = port_data[rd_bank[i]][(rd_slot[i] == SLOT_B) ? 1 : 0];
    end
  end
endmodule

// File: tb/wrbank_regfile_test.sv
module wrbank_regfile_test;
  localparam int NB = 4, RG = 8, LG = 2, DW = 16, TW = 6, NR = 6, NF = 2;
  localparam int BW = 2, IW = 3, PW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NB-1:0]          alloc_valid = '0;
  logic [NB-1:0][TW-1:0]  alloc_tag = '0;
  logic [NB-1:0]          alloc_oldest = '0;
  logic [NB-1:0][IW-1:0]  alloc_old_idx = '0;
  logic [NB-1:0]          alloc_ready;
  logic [NB-1:0][PW-1:0]  alloc_preg;
  logic [NB-1:0][DW-1:0]  res_data = '0;
  logic [NF-1:0]          free_valid = '0;
  logic [NF-1:0][PW-1:0]  free_preg = '0;
  logic [NR-1:0]          rd_valid = '0;
  logic [NR-1:0][PW-1:0]  rd_preg = '0;
  logic [NR-1:0]          rd_grant, rd_fail;
  logic [NR-1:0][DW-1:0]  rd_data;
  logic [NB-1:0]          bc_valid;
  logic [NB-1:0][TW-1:0]  bc_tag;
  logic [NB-1:0][PW-1:0]  bc_preg;

  wrbank_regfile uut (.*);

  always #10 clk = ~clk;  // 50 MHz

  int vectors = 0, miscompares = 0, cyc = 0;
  bit finished = 0;

  // behavioural reference state
  bit          m_free [NB][RG];
  int          m_mem  [NB][RG];
  bit          pend_v [NB][4];
  int          pend_i [NB][4];
  bit          mbc_v  [NB];
  int          mbc_tag[NB], mbc_preg[NB];

  task automatic chk(bit ok, string req, int act, int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: got %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic int low_free(int b);
    for (int r = 0; r < RG; r++) if (m_free[b][r]) return r;
    return -1;
  endfunction

  task automatic model_reset();
    for (int b = 0; b < NB; b++) begin
      for (int r = 0; r < RG; r++) begin
        m_free[b][r] = (r >= LG);
        m_mem[b][r]  = 0;
      end
      for (int k = 0; k < 4; k++) pend_v[b][k] = 0;
      mbc_v[b] = 0;
    end
  endtask

  task automatic clear_stim();
    alloc_valid = '0; alloc_oldest = '0; free_valid = '0; rd_valid = '0;
  endtask

  // one clock: drive, predict and compare, then advance the model
  task automatic run_cycle();
    int used [NB];
    int er [NB], ei [NB];
    #2;
    for (int b = 0; b < NB; b++) begin
      int lf = low_free(b);
      er[b] = (alloc_oldest[b] || lf >= 0) ? 1 : 0;
      ei[b] = alloc_oldest[b] ? int'(alloc_old_idx[b]) : lf;
      chk(alloc_ready[b] == er[b][0], alloc_oldest[b] ? "R8" : (er[b] != 0 ? "R2" : "R3"),
          int'(alloc_ready[b]), er[b]);
      if (alloc_valid[b] && er[b] != 0)
        chk(int'(alloc_preg[b]) == b * RG + ei[b], alloc_oldest[b] ? "R8" : "R2",
            int'(alloc_preg[b]), b * RG + ei[b]);
      chk(bc_valid[b] == mbc_v[b], "R9", int'(bc_valid[b]), int'(mbc_v[b]));
      if (mbc_v[b]) begin
        chk(int'(bc_tag[b]) == mbc_tag[b], "R9", int'(bc_tag[b]), mbc_tag[b]);
        chk(int'(bc_preg[b]) == mbc_preg[b], "R9", int'(bc_preg[b]), mbc_preg[b]);
      end
      used[b] = 0;
    end
    for (int i = 0; i < NR; i++) begin
      int pb = int'(rd_preg[i]) / RG, pi = int'(rd_preg[i]) % RG;
      if (rd_valid[i]) begin
        if (used[pb] < 2) begin
          chk(rd_grant[i] && !rd_fail[i], "R6", int'({rd_grant[i], rd_fail[i]}), 2);
          chk(int'(rd_data[i]) == m_mem[pb][pi], "R7", int'(rd_data[i]), m_mem[pb][pi]);
        end else begin
          chk(!rd_grant[i] && rd_fail[i], "R6", int'({rd_grant[i], rd_fail[i]}), 1);
        end
        used[pb]++;
      end else begin
        chk(!rd_grant[i] && !rd_fail[i], "R6", int'({rd_grant[i], rd_fail[i]}), 0);
      end
    end
    // advance model to the state after the coming edge
    for (int b = 0; b < NB; b++) begin
      int due = (cyc + 2) % 4;
      if (pend_v[b][due]) begin
        m_mem[b][pend_i[b][due]] = int'(res_data[b]);
        pend_v[b][due] = 0;
      end
      mbc_v[b] = alloc_valid[b] && er[b] != 0;
      if (mbc_v[b]) begin
        pend_v[b][cyc % 4] = 1;
        pend_i[b][cyc % 4] = ei[b];
        if (!alloc_oldest[b]) m_free[b][ei[b]] = 0;
        mbc_tag[b]  = int'(alloc_tag[b]);
        mbc_preg[b] = b * RG + ei[b];
      end
    end
    for (int f = 0; f < NF; f++)
      if (free_valid[f]) m_free[int'(free_preg[f]) / RG][int'(free_preg[f]) % RG] = 1;
    @(negedge clk);
    cyc++;
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: idle after reset, all ready, no broadcast, logical registers read zero
    for (int i = 0; i < 4; i++) begin
      rd_valid[i] = 1'b1;
      rd_preg[i] = PW'((i % 2) * RG + (i / 2));  // banks 0 and 1, index 0 and 1
    end
    #2;
    chk(alloc_ready == '1, "R1", int'(alloc_ready), 15);
    chk(bc_valid == '0, "R1", int'(bc_valid), 0);
    chk(rd_data[0] == '0 && rd_data[3] == '0, "R1", int'(rd_data[3]), 0);
    run_cycle();
    // R6: five reads on bank 2, requesters 0..4; 0,1 granted, 2..4 fail
    clear_stim();
    for (int i = 0; i < 5; i++) begin rd_valid[i] = 1'b1; rd_preg[i] = PW'(2 * RG + i); end
    #2;
    chk(rd_grant == 6'b000011 && rd_fail == 6'b011100, "R6", int'(rd_fail), 28);
    run_cycle();
    // R1: first allocation on bus 1 gets index LOGICAL_PER_BANK
    clear_stim();
    alloc_valid[1] = 1'b1; alloc_tag[1] = 6'd9; res_data[1] = 16'hBEEF;
    #2;
    chk(int'(alloc_preg[1]) == RG + LG, "R1", int'(alloc_preg[1]), RG + LG);
    run_cycle();
    clear_stim();
    run_cycle();
    res_data[1] = 16'h1234;  // written now: two cycles after acceptance
    run_cycle();
    // R5: read it back
    rd_valid[0] = 1'b1; rd_preg[0] = PW'(RG + LG);
    #2;
    chk(rd_data[0] == 16'h1234, "R5", int'(rd_data[0]), 32'h1234);
    run_cycle();
    // R3: drain bank 0 (six free registers) then stall
    clear_stim();
    for (int k = 0; k < 7; k++) begin
      alloc_valid[0] = 1'b1; alloc_tag[0] = TW'(k); res_data[0] = DW'(16'hA000 + k);
      run_cycle();
    end
    alloc_valid[0] = 1'b1;
    #2;
    chk(alloc_ready[0] == 1'b0, "R3", int'(alloc_ready[0]), 0);
    run_cycle();
    // R8: oldest instruction is accepted on its old register while bank 0 is empty
    alloc_oldest[0] = 1'b1; alloc_old_idx[0] = 3'd1; alloc_tag[0] = 6'd33;
    #2;
    chk(alloc_ready[0] && int'(alloc_preg[0]) == 1, "R8", int'(alloc_preg[0]), 1);
    run_cycle();
    // R4: release register 3 of bank 0, stalled request retries and gets it
    alloc_oldest[0] = 1'b0; alloc_valid[0] = 1'b1;
    free_valid[0] = 1'b1; free_preg[0] = PW'(3);
    run_cycle();
    free_valid = '0;
    #2;
    chk(alloc_ready[0] && int'(alloc_preg[0]) == 3, "R4", int'(alloc_preg[0]), 3);
    run_cycle();
    // R10: all buses together with free registers in every bank
    clear_stim();
    free_valid[0] = 1'b1; free_preg[0] = PW'(5);
    run_cycle();
    clear_stim();
    alloc_valid = '1;
    #2;
    chk(alloc_ready == '1, "R10", int'(alloc_ready), 15);
    run_cycle();
    // random mixed traffic against the model
    for (int n = 0; n < 4000; n++) begin
      for (int b = 0; b < NB; b++) begin
        alloc_valid[b]   = 1'($urandom % 2);
        alloc_oldest[b]  = 1'(($urandom % 10) == 0);
        alloc_old_idx[b] = IW'($urandom);
        alloc_tag[b]     = TW'($urandom);
        res_data[b]      = DW'($urandom);
      end
      for (int f = 0; f < NF; f++) begin
        free_valid[f] = 1'(($urandom % 4) == 0);
        free_preg[f]  = PW'($urandom);
      end
      for (int i = 0; i < NR; i++) begin
        rd_valid[i] = 1'($urandom % 2);
        rd_preg[i]  = PW'($urandom);
      end
      run_cycle();
    end
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      finished = 1;
      miscompares++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule